// File: doc/BRIEF.md
# Memory-Mapped 64-Line Interrupt Controller

This block gathers 64 interrupt input lines behind an APB slave port and folds them into a single interrupt request for the processor. The 64 interrupt positions are called channels. A programmable slot table chooses which input line feeds each channel. For every channel the block keeps an enable bit and a sticky capture bit. The capture bit records a rising edge, so a short pulse is not lost after the line drops. A single global enable bit gates the whole controller.

Software reads the pending state as two 32-bit words: a low word for channels 31..0 and a high word for channels 63..32. It services a pulse-type channel by writing the capture word back with that channel's bit cleared. The request output is the registered OR of all pending channels. The port has no wait states and never signals an error.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset, the control word, both enable words and both capture words read 0 and `irq_o` is low. The slot table holds the identity mapping, so the word at 0x40 reads 0x03020100 and the word at 0x7C reads 0x3F3E3D3C.
- R2: Bit 31 of the control word at 0x00 is the global enable, and the other control bits read 0. The enable words at 0x10 (channels 31..0) and 0x28 (channels 63..32) read back the last value written to them.
- R3: A channel is pending only when the global enable is set, its enable bit is set, and either its selected input is high or its capture bit is set. The pending words are read at 0x14 (low) and 0x2C (high), and writes to those offsets have no effect.
- R4: While the global enable is clear, both pending words read 0 and `irq_o` is low from the next clock onward.
- R5: A rising edge on a channel's selected input sets that channel's capture bit whether or not the channel is enabled. Capture words are at 0x08 (low) and 0x20 (high), and a capture bit stays set after the input falls.
- R6: Writing a capture word ANDs it with the written data. A 0 clears the bit and a 1 leaves it unchanged, so a write never sets a capture bit.
- R7: `irq_o` is the OR of all 64 pending bits, registered once: it changes at the first rising clock edge after the pending state changes.
- R8: Slot-table word w (offset 0x40 + 4w, w = 0..15) holds channels 4w..4w+3, with channel 4w+k in byte k. Bits [5:0] of each byte give the input line index, and bits [7:6] read 0. Each channel takes its level and its edge from the line it selects.
- R9: Reads of any offset not listed above, including misaligned offsets, return 0, and writes to those offsets change no state. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| src_i | input | 64 | Interrupt input lines |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Read data and pending words are combinational: the bench samples `prdata` 1 ns into the access phase, and register writes take effect at the clock edge that ends the access phase. An edge on an input line is captured at the first rising clock after the line rises. `irq_o` follows the pending state one rising clock later. The bench therefore drives lines on a falling edge and checks that `irq_o` is still low 1 ns later. It then checks that `irq_o` is high at the next falling edge. After a write that clears pending state, it waits one further falling edge before checking that the request has dropped.

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [63:0]       src_i,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o
);
  localparam int NSRC  = 64;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_FLO  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_ELO  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_FHI  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_EHI  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'('h2C);

  logic             gen_q, irq_q;
  logic [NSRC-1:0]  en_q, flag_q, src_q, lvl, edg, pend;
  logic [IDX_W-1:0] slot_map [NSRC];
  logic [31:0]      rd;

  wire wr      = psel & penable & pwrite;
  wire map_hit = (paddr[ADDR_W-1:6] == (ADDR_W-6)'(1)) && (paddr[1:0] == 2'b00);
  wire [3:0] map_word = paddr[5:2];
  wire any_hit = map_hit || paddr == A_CTRL || paddr == A_FLO || paddr == A_ELO ||
                 paddr == A_PLO || paddr == A_FHI || paddr == A_EHI || paddr == A_PHI;

  wire [NSRC-1:0] rise = src_i & ~src_q;

  for (genvar n = 0; n < NSRC; n++) begin : g_slot
    assign lvl[n] = src_i[slot_map[n]];
    assign edg[n] = rise[slot_map[n]];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) slot_map[n] <= IDX_W'(n);
      else if (wr && map_hit && map_word == 4'(n / 4))
        slot_map[n] <= pwdata[8*(n%4) +: IDX_W];
  end

  assign pend = {NSRC{gen_q}} & en_q & (lvl | flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
      src_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      irq_q <= |pend;
      if (wr && paddr == A_CTRL) gen_q <= pwdata[31];
      if (wr && paddr == A_ELO)  en_q[31:0]  <= pwdata;
      if (wr && paddr == A_EHI)  en_q[63:32] <= pwdata;
      flag_q[31:0]  <= ((wr && paddr == A_FLO) ? (flag_q[31:0]  & pwdata) : flag_q[31:0])  | edg[31:0];
      flag_q[63:32] <= ((wr && paddr == A_FHI) ? (flag_q[63:32] & pwdata) : flag_q[63:32]) | edg[63:32];
    end
  end

  always_comb begin
    rd = '0;
    if (map_hit) begin
      for (int k = 0; k < 4; k++)
        rd[8*k +: 8] = 8'(slot_map[int'(map_word)*4 + k]);
    end else begin
      case (paddr)
        A_CTRL:  rd = {gen_q, 31'b0};
        A_FLO:   rd = flag_q[31:0];
        A_ELO:   rd = en_q[31:0];
        A_PLO:   rd = pend[31:0];
        A_FHI:   rd = flag_q[63:32];
        A_EHI:   rd = en_q[63:32];
        A_PHI:   rd = pend[63:32];
        default: rd = '0;
      endcase
    end
  end

  assign prdata  = rd;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !gen_q |=> !irq_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr == A_FLO) |=> ((flag_q[31:0] & $past(flag_q[31:0])) == $past(flag_q[31:0]))); // R5
  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == A_PLO) |-> ((prdata & ~en_q[31:0]) == 32'h0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && !any_hit) |-> (prdata == 32'h0)); // R9
  AST_MAP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && map_hit) |-> ((prdata & 32'hC0C0C0C0) == 32'h0)); // R8
endmodule

// File: tb/apb_irq_ctrl_bench.sv
`timescale 1ns/1ps
module apb_irq_ctrl_bench;
  logic clk = 0, rst_n = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [63:0] src_i = '0;
  logic pready, pslverr, irq_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  apb_irq_ctrl #(.ADDR_W(8)) u_apb_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .src_i(src_i), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", 8'h00, 0);
    rchk("R1 en lo", 8'h10, 0);
    rchk("R1 en hi", 8'h28, 0);
    rchk("R1 flag lo", 8'h08, 0);
    rchk("R1 flag hi", 8'h20, 0);
    rchk("R1 map w0", 8'h40, 32'h03020100);
    rchk("R1 map w15", 8'h7C, 32'h3F3E3D3C);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R9 pready", {31'b0, pready}, 1);
    chk("R9 pslverr", {31'b0, pslverr}, 0);
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hFFFFFFFF);
    rchk("R2 ctrl only bit31", 8'h00, 32'h80000000);
    wr(8'h28, 32'hA5A5_0F0F);
    rchk("R2 en hi readback", 8'h28, 32'hA5A5_0F0F);
    wr(8'h28, 0);
    wr(8'h10, 32'h0000_0010);
    rchk("R2 en lo readback", 8'h10, 32'h10);
  endtask

  task automatic t_level_and_flag;
    @(negedge clk); src_i[4] = 1;
    #1 chk("R7 irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 irq after one edge", {31'b0, irq_o}, 1);
    rchk("R3 pend lo", 8'h14, 32'h10);
    rchk("R5 flag lo set", 8'h08, 32'h10);
    @(negedge clk); src_i[4] = 0;
    @(negedge clk);
    rchk("R5 sticky pend", 8'h14, 32'h10);
    wr(8'h08, 32'h0);
    @(negedge clk);
    chk("R6/R7 irq dropped", {31'b0, irq_o}, 0);
    rchk("R6 flag cleared", 8'h08, 0);
    rchk("R3 pend cleared", 8'h14, 0);
  endtask

  task automatic t_disabled;
    @(negedge clk); src_i[5] = 1;
    @(negedge clk);
    rchk("R3 disabled not pending", 8'h14, 0);
    chk("R3 irq low", {31'b0, irq_o}, 0);
    rchk("R5 capture while disabled", 8'h08, 32'h20);
    @(negedge clk); src_i[5] = 0;
    wr(8'h08, 0);
  endtask

  task automatic t_global_off;
    @(negedge clk); src_i[4] = 1;
    @(negedge clk);
    chk("R7 irq on", {31'b0, irq_o}, 1);
    wr(8'h00, 0);
    @(negedge clk);
    chk("R4 irq off", {31'b0, irq_o}, 0);
    rchk("R4 pend lo zero", 8'h14, 0);
    @(negedge clk); src_i[4] = 0;
    wr(8'h08, 0);
    wr(8'h00, 32'h80000000);
  endtask

  task automatic t_high_word;
    wr(8'h28, 32'h1);
    @(negedge clk); src_i[32] = 1;
    @(negedge clk); src_i[32] = 0;
    rchk("R5 flag hi", 8'h20, 32'h1);
    rchk("R3 pend hi", 8'h2C, 32'h1);
    wr(8'h20, 32'hFFFFFFFF);
    rchk("R6 write one keeps/no set", 8'h20, 32'h1);
    wr(8'h14, 32'hFFFFFFFF);
    wr(8'h2C, 0);
    rchk("R3 pend write ignored", 8'h2C, 32'h1);
    rchk("R3 en lo untouched", 8'h10, 32'h10);
    wr(8'h20, 0);
    rchk("R6 flag hi cleared", 8'h20, 0);
    wr(8'h28, 0);
  endtask

  task automatic t_remap;
    wr(8'h40, 32'hC302013F);
    rchk("R8 map readback", 8'h40, 32'h0302013F);
    wr(8'h10, 32'h1);
    @(negedge clk); src_i[0] = 1;
    @(negedge clk);
    rchk("R8 old source ignored", 8'h14, 0);
    src_i[0] = 0; src_i[63] = 1;
    @(negedge clk);
    rchk("R8 new source pending", 8'h14, 32'h1);
    rchk("R8 identity slot63 flag", 8'h20, 32'h80000000);
    rchk("R8 slot0 flag", 8'h08, 32'h1);
    @(negedge clk); src_i[63] = 0;
    wr(8'h08, 0); wr(8'h20, 0);
    wr(8'h40, 32'h03020100);
    wr(8'h10, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h10, 32'h0000_00FF);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h12, 32'hFFFFFFFF);
    wr(8'h80, 32'hFFFFFFFF);
    rchk("R9 read 0x04", 8'h04, 0);
    rchk("R9 read 0x30", 8'h30, 0);
    rchk("R9 read 0x12", 8'h12, 0);
    rchk("R9 read 0x80", 8'h80, 0);
    rchk("R9 en lo unchanged", 8'h10, 32'hFF);
    rchk("R9 en hi unchanged", 8'h28, 0);
    rchk("R9 flags unchanged", 8'h08, 0);
    rchk("R9 ctrl unchanged", 8'h00, 32'h80000000);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_level_and_flag();
    t_disabled();
    t_global_off();
    t_high_word();
    t_remap();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule